// File: doc/BRIEF.md
# Instruction-Cache Tag Store with Memory-Mapped Maintenance Port

This block holds the tag half of a four-way set-associative instruction cache. It has 256 sets, and each way of a set keeps a 19-bit tag and a valid flag. Software reaches the store through a small memory-mapped request port. Three operations are available: a read of one way's tag and valid flag, a direct write of one way, and a tag-matched write. The tag-matched write looks at every way of one set and changes the valid flag only where the stored tag equals the supplied tag.

Cache maintenance code uses the tag-matched write to invalidate one line by address without knowing which way holds it. When no way holds the line, the operation does nothing and raises no error. The same is true when the optional address-translation lookup reports a miss. When translation is enabled, the tag that is compared comes from an external lookup port in the same cycle. When translation is off, the tag bits of the write data are compared directly.

Top module: `ictag_port`

## Requirements
- R1: A request is taken only when `req_addr[31:24]` is 8'hF0. Any other request gets no `rsp_ready` and changes no stored tag or valid flag.
- R2: In the address, the way number is in `[14:13]`, the set index is in `[12:5]` and the match-mode flag is in bit 3. A read returns the addressed way and set with the tag in `rsp_rdata[28:10]` and the valid flag in `rsp_rdata[0]`. The match-mode flag has no effect on a read.
- R3: A write with the match-mode flag at 0 stores `req_wdata[28:10]` as the tag and `req_wdata[0]` as the valid flag of the addressed way and set. `req_wdata[31:29]` are dropped.
- R4: A write with the match-mode flag at 1 ignores the way bits. Every way of the addressed set whose valid flag is 1 and whose tag equals the compare tag has its valid flag replaced by `req_wdata[0]`. Its stored tag stays unchanged.
- R5: In a tag-matched write, a way whose valid flag is 0 is never changed, even when its tag equals the compare tag. When no way qualifies, nothing changes.
- R6: With `xlat_en` = 1, `xlat_vtag` presents `req_wdata[31:10]` and the compare tag is `xlat_ptag`. If `xlat_miss` is 1, the tag-matched write changes nothing.
- R7: With `xlat_en` = 0, the compare tag is `req_wdata[28:10]`, and `xlat_ptag` and `xlat_miss` have no effect.
- R8: `rsp_ready` is a one-cycle pulse in the cycle after an accepted request. Read data is valid with it, and a write is visible to the next request.
- R9: `rsp_rdata[31:29]` and `rsp_rdata[9:1]` are always 0, and the whole of `rsp_rdata` is 0 after a write.
- R10: A synchronous active-low reset clears every valid flag and every tag, and drops `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Address: region, way, set and match-mode flag |
| req_wdata | input | 32 | Write data: tag in [31:10], valid flag in bit 0 |
| rsp_ready | output | 1 | Completion pulse |
| rsp_rdata | output | 32 | Read data in the write-data layout |
| xlat_en | input | 1 | Static enable for tag translation |
| xlat_vtag | output | 22 | Virtual tag bits sent to the translation lookup |
| xlat_ptag | input | 19 | Translated physical tag, same cycle |
| xlat_miss | input | 1 | Translation lookup found no mapping |

## Verification
The bench builds a set where two valid ways, one valid way with another tag, and one invalid way with the same tag sit side by side. It then issues a tag-matched write addressed at the wrong way. A design that honoured the way bits would clear only one line. A design that skipped the valid check would touch the invalid way, and one that stopped at the first hit would leave the second copy valid. Further cases cover the following:
- translation hits, misses, and a disabled lookup carrying a tempting `xlat_ptag`, which expose a design that compares the wrong tag source or ignores the miss flag;
- writes whose high tag bits are set, and accesses outside the F0 region, which show truncation and decode errors;
- a mid-run reset, which checks that every valid flag is cleared.

// File: rtl/ictag_pkg.sv
// Shared constants and helpers for the instruction-cache tag store.
// Assumes a 32-bit request bus with the data layout fixed by the port spec.
package ictag_pkg;
    localparam int          BUS_W      = 32;
    localparam logic [7:0]  REGION_TAG = 8'hF0;
    localparam int          WAY_LSB    = 13;
    localparam int          IDX_LSB    = 5;
    localparam int          MODE_BIT   = 3;
    localparam int          TAG_LSB    = 10;
    localparam int          VTAG_W     = BUS_W - TAG_LSB;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WDIR  = 2'd2,
        OP_WMTCH = 2'd3
    } op_e;
endpackage

// File: rtl/ictag_decode.sv
// Splits a request into operation, way, set index and write fields.
// Assumes the region byte sits in address bits [31:24].
module ictag_decode
    import ictag_pkg::*;
#(
    parameter int WAY_W = 2,
    parameter int IDX_W = 8,
    parameter int TAG_W = 19
) (
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [BUS_W-1:0]     req_addr,
    input  logic [BUS_W-1:0]     req_wdata,
    output op_e                  op,
    output logic [WAY_W-1:0]     way,
    output logic [IDX_W-1:0]     idx,
    output logic [TAG_W-1:0]     wtag,
    output logic                 wvld
);
    logic hit_region;

    // Region match and operation selection.
    always_comb begin
        hit_region = (req_addr[BUS_W-1 -: 8] == REGION_TAG);
        if (!(req_valid && hit_region))     op = OP_NONE;
        else if (!req_write)                op = OP_READ;
        else if (req_addr[MODE_BIT])        op = OP_WMTCH;
        else                                op = OP_WDIR;
    end

    // Field extraction.
    assign way  = req_addr[WAY_LSB +: WAY_W];
    assign idx  = req_addr[IDX_LSB +: IDX_W];
    assign wtag = req_wdata[TAG_LSB +: TAG_W];
    assign wvld = req_wdata[0];

    logic unused_bits;
    assign unused_bits = ^{req_addr[23:15], req_addr[4], req_addr[2:0],
                           req_wdata[BUS_W-1:TAG_LSB+TAG_W], req_wdata[TAG_LSB-1:1]};
endmodule

// File: rtl/ictag_way.sv
// One way of the tag store: a tag array and a valid vector.
// Reads are combinational. Both kinds of write are applied at the clock edge.
// The tag-only-valid update leaves the tag untouched.
module ictag_way #(
    parameter int ENTRIES = 256,
    parameter int TAG_W   = 19,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_vld,
    input  logic              wr_full,
    input  logic              wr_vonly,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_vld
);
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;

    // Tag storage: cleared on reset, written on a direct write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '0;
        end else if (wr_full) begin
            tag_q[idx] <= wr_tag;
        end
    end

    // Valid storage: cleared on reset, written on either write kind.
    always_ff @(posedge clk) begin
        if (!rst_n)                   vld_q      <= '0;
        else if (wr_full || wr_vonly) vld_q[idx] <= wr_vld;
    end

    assign rd_tag = tag_q[idx];
    assign rd_vld = vld_q[idx];
endmodule

// File: rtl/ictag_match.sv
// Per-way tag comparison for the tag-matched write.
// A way qualifies only when it is valid and its tag equals the compare tag.
module ictag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 19
) (
    input  logic [TAG_W-1:0] way_tag [WAYS],
    input  logic [WAYS-1:0]  way_vld,
    input  logic [TAG_W-1:0] cmp_tag,
    output logic [WAYS-1:0]  hit
);
    // One comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit[w] = way_vld[w] && (way_tag[w] == cmp_tag);
    end
endmodule

// File: rtl/ictag_port.sv
// Memory-mapped tag store port for a set-associative instruction cache.
// The port offers three operations: read, direct write, and tag-matched valid update.
// Assumes one request per cycle at most. The response is registered and
// arrives one cycle later. The translation lookup answers combinationally.
module ictag_port
    import ictag_pkg::*;
#(
    parameter int WAYS    = 4,
    parameter int ENTRIES = 256,
    parameter int TAG_W   = 19,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_ready,
    output logic [31:0]       rsp_rdata,
    input  logic              xlat_en,
    output logic [21:0]       xlat_vtag,
    input  logic [TAG_W-1:0]  xlat_ptag,
    input  logic              xlat_miss
);
    op_e               op;
    logic [WAY_W-1:0]  way;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  wtag;
    logic              wvld;
    logic [TAG_W-1:0]  way_tag [WAYS];
    logic [WAYS-1:0]   way_vld;
    logic [WAYS-1:0]   hit;
    logic [TAG_W-1:0]  cmp_tag;
    logic              mtch_go;
    logic [31:0]       rd_word;

    ictag_decode #(.WAY_W(WAY_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .op        (op),
        .way       (way),
        .idx       (idx),
        .wtag      (wtag),
        .wvld      (wvld)
    );

    // Compare tag source and gate for the tag-matched write.
    assign xlat_vtag = req_wdata[31:TAG_LSB];
    assign cmp_tag   = xlat_en ? xlat_ptag : wtag;
    assign mtch_go   = (op == OP_WMTCH) && !(xlat_en && xlat_miss);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        ictag_way #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_way (
            .clk      (clk),
            .rst_n    (rst_n),
            .idx      (idx),
            .rd_tag   (way_tag[w]),
            .rd_vld   (way_vld[w]),
            .wr_full  ((op == OP_WDIR) && (way == WAY_W'(w))),
            .wr_vonly (mtch_go && hit[w]),
            .wr_tag   (wtag),
            .wr_vld   (wvld)
        );
    end

    ictag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .way_tag (way_tag),
        .way_vld (way_vld),
        .cmp_tag (cmp_tag),
        .hit     (hit)
    );

    // Format the addressed way into the data-field layout. Reserved bits are zero.
    always_comb begin
        rd_word              = '0;
        rd_word[TAG_LSB +: TAG_W] = way_tag[way];
        rd_word[0]           = way_vld[way];
    end

    // Response register: a one-cycle ready pulse, with data only for reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ready <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_ready <= (op != OP_NONE);
            rsp_rdata <= (op == OP_READ) ? rd_word : '0;
        end
    end
endmodule

// File: rtl/ictag_port_chk.sv
// Protocol checker for ictag_port, attached through bind.
// Sees only the top-level ports.
module ictag_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [31:0] req_addr,
    input logic        rsp_ready,
    input logic [31:0] rsp_rdata
);
    AST_FOREIGN_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_addr[31:24] != 8'hF0 |=> !rsp_ready); // R1
    AST_READY_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_addr[31:24] == 8'hF0 |=> rsp_ready); // R8
    AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_ready); // R8
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> rsp_rdata[9:1] == 9'd0 && rsp_rdata[31:29] == 3'd0); // R9
    AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write |=> rsp_rdata == 32'd0); // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !rsp_ready); // R10
endmodule

bind ictag_port ictag_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata)
);

// File: tb/sim_ictag_port.sv
module sim_ictag_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        rsp_ready;
    logic [31:0] rsp_rdata;
    logic        xlat_en = 1'b0;
    logic [21:0] xlat_vtag;
    logic [18:0] xlat_ptag = '0;
    logic        xlat_miss = 1'b0;

    int checks = 0, failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ictag_port u0 (.*);

    function automatic logic [31:0] mk_addr(int way, int idx, bit mode, logic [7:0] region = 8'hF0);
        return {region, 24'd0} | (32'(way) << 13) | (32'(idx) << 5) | (32'(mode) << 3);
    endfunction

    function automatic logic [31:0] mk_data(logic [21:0] tag22, bit v);
        return (32'(tag22) << 10) | 32'(v);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic        l_rdy;
    logic [31:0] l_rd;
    logic [21:0] l_vt;

    task automatic access(bit wr, logic [31:0] a, logic [31:0] d,
                          logic [18:0] pt = '0, bit ms = 0);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        xlat_ptag = pt; xlat_miss = ms;
        #1 l_vt = xlat_vtag;
        @(posedge clk);
        #1 l_rdy = rsp_ready; l_rd = rsp_rdata;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd_expect(string req, int way, int idx, logic [18:0] tag, bit v);
        access(0, mk_addr(way, idx, 0), '0);
        chk(req, {31'd0, l_rdy}, 32'd1);
        chk(req, l_rd, {3'd0, tag, 9'd0, v});
    endtask

    task automatic wr_dir(int way, int idx, logic [21:0] t22, bit v);
        access(1, mk_addr(way, idx, 0), mk_data(t22, v));
    endtask

    task automatic t_reset();
        rd_expect("R10 reset w0", 0, 0, '0, 0);
        rd_expect("R10 reset w3", 3, 255, '0, 0);
    endtask

    task automatic t_direct();
        wr_dir(1, 5, 22'h3F_1234, 1);              // top bits [31:29] set
        chk("R9 write rdata zero", l_rd, 32'd0);
        chk("R8 write ready", {31'd0, l_rdy}, 32'd1);
        @(posedge clk); #1 chk("R8 single pulse", {31'd0, rsp_ready}, 32'd0);
        rd_expect("R3 tag truncated", 1, 5, 19'h7_1234, 1);
        rd_expect("R3 other way untouched", 0, 5, '0, 0);
        access(0, mk_addr(1, 5, 1), '0);
        chk("R2 mode flag ignored on read", l_rd, {3'd0, 19'h7_1234, 9'd0, 1'b1});
    endtask

    task automatic t_region();
        access(1, mk_addr(1, 5, 0, 8'hF1), mk_data(22'h00_0055, 0));
        chk("R1 foreign no ready", {31'd0, l_rdy}, 32'd0);
        rd_expect("R1 foreign no change", 1, 5, 19'h7_1234, 1);
    endtask

    task automatic t_match();
        wr_dir(0, 9, 22'h0_0A0A, 1);
        wr_dir(1, 9, 22'h0_0B0B, 1);
        wr_dir(2, 9, 22'h0_0A0A, 1);
        wr_dir(3, 9, 22'h0_0A0A, 0);
        access(1, mk_addr(3, 9, 1), mk_data(22'h0_0A0A, 0));
        chk("R4 ready", {31'd0, l_rdy}, 32'd1);
        rd_expect("R4 way0 cleared", 0, 9, 19'h0_0A0A, 0);
        rd_expect("R4 way2 cleared", 2, 9, 19'h0_0A0A, 0);
        rd_expect("R4 way1 other tag", 1, 9, 19'h0_0B0B, 1);
        rd_expect("R5 invalid way kept", 3, 9, 19'h0_0A0A, 0);
        access(1, mk_addr(0, 9, 1), mk_data(22'h0_0C0C, 0));
        rd_expect("R5 no match no change", 1, 9, 19'h0_0B0B, 1);
        access(1, mk_addr(0, 9, 1), mk_data(22'h0_0A0A, 1));
        rd_expect("R5 invalid not revived", 0, 9, 19'h0_0A0A, 0);
    endtask

    task automatic t_xlat();
        wr_dir(2, 20, 22'h0_1111, 1);
        wr_dir(3, 20, 22'h0_2222, 1);
        xlat_en = 1;
        access(1, mk_addr(0, 20, 1), mk_data(22'h2A_5555, 0), 19'h0_2222, 1);
        chk("R6 vtag out", {10'd0, l_vt}, {10'd0, 22'h2A_5555});
        rd_expect("R6 miss no change", 3, 20, 19'h0_2222, 1);
        access(1, mk_addr(0, 20, 1), mk_data(22'h2A_5555, 0), 19'h0_2222, 0);
        rd_expect("R6 translated hit", 3, 20, 19'h0_2222, 0);
        rd_expect("R6 other way kept", 2, 20, 19'h0_1111, 1);
        xlat_en = 0;
        access(1, mk_addr(0, 20, 1), mk_data(22'h00_0999, 0), 19'h0_1111, 0);
        rd_expect("R7 ptag ignored", 2, 20, 19'h0_1111, 1);
        access(1, mk_addr(0, 20, 1), mk_data(22'h00_1111, 0), 19'h0_0999, 1);
        rd_expect("R7 raw compare miss ignored", 2, 20, 19'h0_1111, 0);
    endtask

    task automatic t_midreset();
        wr_dir(0, 40, 22'h0_4444, 1);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        chk("R10 ready low", {31'd0, rsp_ready}, 32'd0);
        rd_expect("R10 valid cleared", 0, 40, '0, 0);
        rd_expect("R10 older entry cleared", 1, 9, '0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_direct();
        t_region();
        t_match();
        t_xlat();
        t_midreset();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule